// File: doc/BRIEF.md
# Coprocessor Control-Register Move Sequencer

This block serves a single class of coprocessor command: moving any chosen subset of three 32-bit registers to or from memory. The three registers live inside the block: a control register, a status register and an instruction-address register. The host CPU writes a 16-bit command word. The block decodes from it a transfer direction and a 3-bit register select. It then offers the host two response primitives, one after the other. The first asks the host to evaluate an effective address and move data. It carries the total byte count and the class of addressing modes that the host may accept. The second is a null primitive that closes the exchange.

Between the two primitives the host moves the selected registers, one 32-bit word per data-port strobe. Loads write the block's registers and stores read them. The order is always control, then status, then instruction address, and registers that are not selected are skipped. The block only reports the allowed addressing class. Computing addresses, checking addressing modes and running bus cycles are the host's job.

Top module: `cp_ctlmove_seq`

## Requirements
- R1: A command word is accepted only while the block is idle and only when bits [15:14] equal 2'b10 and bits [9:0] are all zero. Bit 13 is the direction (0 = load into the block, 1 = store from the block) and bits [12:10] are the select. Any other word leaves the block idle, with rsp_valid low.
- R2: The byte count in rsp_word[7:0] of the first primitive is 4 times the number of selected registers: 4, 8 or 12.
- R3: Select 3'b000 acts exactly like 3'b001. Only the instruction-address register moves, the byte count is 4, and the class is the one for that register alone.
- R4: The class code in rsp_word[10:8] depends on direction and selection. With several registers selected it is 2 for loads and 5 for stores. With only the instruction-address register it is 0 for loads and 3 for stores. With only the control or status register it is 1 for loads and 4 for stores.
- R5: The first primitive has rsp_word[15:13]=3'b001 and the come-again bit rsp_word[12]=1. The null primitive is all zeros. Bit 11 is always 0. Each primitive is held with rsp_valid high until rsp_rd pops it. Popping the null primitive returns the block to idle.
- R6: Select bit 2 is the control register, bit 1 the status register and bit 0 the instruction-address register. Words move in that order, and unselected registers are skipped. During a store transfer, dat_rdata shows the register due next; at all other times it is 0.
- R7: During a load transfer, each dat_wr writes dat_wdata into the register due next. A dat_rd during a load, a dat_wr during a store, and any data strobe outside the transfer phase change no register and move no word.
- R8: rsp_valid stays low during the transfer phase. The null primitive appears in the cycle after the last selected word has moved.
- R9: A synchronous active-high rst clears all three registers to zero and returns the block to idle.
- R10: A command write while the block is not idle is ignored. The exchange that is running continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| rsp_rd | input | 1 | Pops the current response primitive |
| rsp_valid | output | 1 | A response primitive is available |
| rsp_word | output | 16 | Response primitive (0 when none is available) |
| dat_wr | input | 1 | Host writes one word (load direction) |
| dat_wdata | input | 32 | Data word for the register due next |
| dat_rd | input | 1 | Host takes one word (store direction) |
| dat_rdata | output | 32 | Register due next during a store |
| ctl_reg | output | 32 | Control register |
| sts_reg | output | 32 | Status register |
| iar_reg | output | 32 | Instruction-address register |

## Verification
The bench first exercises each select size on its own:
- A single control or status register separates the data classes from the any/alterable classes.
- The instruction-address register alone, and the reserved zero select, show the alias to the single instruction-address case.
- Pairs with gaps, such as control plus instruction address, prove that skipped registers keep the fixed order.
- All three registers check the 12-byte count.

Wrong-kind data strobes, command writes during an exchange and malformed command words show that no word moves early and no primitive appears out of turn. A long run of random strobes is then compared on every clock against a queue-based model, which checks the primitive order and the register contents together.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int WORD_W = 32;
  localparam int CMD_W  = 16;
  localparam int RSP_W  = 16;
  localparam int NREG   = 3;
  localparam int CNT_W  = $clog2(NREG + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_EVAL, PH_XFER, PH_NULL} phase_t;

  typedef enum logic [2:0] {
    AC_ANY  = 3'd0,
    AC_DATA = 3'd1,
    AC_MEM  = 3'd2,
    AC_ALT  = 3'd3,
    AC_DALT = 3'd4,
    AC_MALT = 3'd5
  } aclass_t;

  localparam logic [2:0] PRIM_EVAL = 3'b001;
  localparam logic [2:0] PRIM_NULL = 3'b000;

  typedef struct packed {
    logic            valid;
    logic            store;
    logic [NREG-1:0] mask;
  } cmd_t;

  // Reserved empty select aliases to the instruction-address register only.
  function automatic logic [NREG-1:0] fold_mask(input logic [NREG-1:0] sel);
    return (sel == '0) ? NREG'(1) : sel;
  endfunction

  function automatic logic [CNT_W-1:0] count_regs(input logic [NREG-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NREG; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  function automatic logic [7:0] byte_count(input logic [NREG-1:0] m);
    return 8'(count_regs(m)) << 2;
  endfunction

  function automatic aclass_t pick_class(input logic store, input logic [NREG-1:0] m);
    if (count_regs(m) > CNT_W'(1)) return store ? AC_MALT : AC_MEM;
    if (m[0])                      return store ? AC_ALT  : AC_ANY;
    return store ? AC_DALT : AC_DATA;
  endfunction

  // Highest set bit wins: control first, instruction address last.
  function automatic logic [NREG-1:0] first_pick(input logic [NREG-1:0] m);
    logic [NREG-1:0] p;
    p = '0;
    for (int i = 0; i < NREG; i++) if (m[i]) p = NREG'(1) << i;
    return p;
  endfunction

  function automatic logic [RSP_W-1:0] pack_eval(input aclass_t c, input logic [7:0] bytes);
    return {PRIM_EVAL, 1'b1, 1'b0, c, bytes};
  endfunction

  function automatic logic [RSP_W-1:0] pack_null();
    return {PRIM_NULL, 1'b0, 12'h000};
  endfunction
endpackage

// File: rtl/cpm_decode.sv
module cpm_decode
  import cpm_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_word,
  output cmd_t             cmd
);
  logic class_ok;

  assign class_ok  = (cmd_word[15:14] == 2'b10) && (cmd_word[9:0] == 10'd0);
  assign cmd.valid = class_ok;
  assign cmd.store = cmd_word[13];
  assign cmd.mask  = fold_mask(cmd_word[12:10]);
endmodule

// File: rtl/cpm_regfile.sv
module cpm_regfile
  import cpm_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0]         wen,
  input  logic [W-1:0]            wdata,
  input  logic [NREG-1:0]         rd_sel,
  output logic [NREG-1:0][W-1:0]  regs_q,
  output logic [W-1:0]            rdata
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)         regs_q[g] <= '0;
      else if (wen[g]) regs_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) if (rd_sel[i]) rdata = rdata | regs_q[i];
  end

  // R6: one register at most is addressed for reading
  assert_single_read_R6: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_sel));
  // R7: one register at most is written per cycle
  assert_single_write_R7: assert property (@(posedge clk) disable iff (rst) $onehot0(wen));
endmodule

// File: rtl/cpm_seq.sv
module cpm_seq
  import cpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  cmd_t             cmd,
  input  logic             rsp_rd,
  input  logic             dat_wr,
  input  logic             dat_rd,
  output phase_t           phase,
  output logic             store_q,
  output logic [NREG-1:0]  pick,
  output logic [NREG-1:0]  wen,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_word
);
  logic [NREG-1:0]  remain_q, mask_q;
  aclass_t          class_q;
  logic [7:0]       bytes_q;
  logic [CNT_W-1:0] moved_q;

  logic ev_accept, ev_pop, ev_move, ev_last;

  assign pick      = (phase == PH_XFER) ? first_pick(remain_q) : '0;
  assign ev_accept = cmd_wr && cmd.valid && (phase == PH_IDLE);
  assign rsp_valid = (phase == PH_EVAL) || (phase == PH_NULL);
  assign ev_pop    = rsp_rd && rsp_valid;
  assign ev_move   = (phase == PH_XFER) && (store_q ? dat_rd : dat_wr);
  assign ev_last   = ev_move && ((remain_q & ~pick) == '0);
  assign wen       = (ev_move && !store_q) ? pick : '0;
  assign rsp_word  = (phase == PH_EVAL) ? pack_eval(class_q, bytes_q) :
                     (phase == PH_NULL) ? pack_null() : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      store_q  <= 1'b0;
      remain_q <= '0;
      mask_q   <= '0;
      class_q  <= AC_ANY;
      bytes_q  <= '0;
      moved_q  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (ev_accept) begin
          phase    <= PH_EVAL;
          store_q  <= cmd.store;
          remain_q <= cmd.mask;
          mask_q   <= cmd.mask;
          class_q  <= pick_class(cmd.store, cmd.mask);
          bytes_q  <= byte_count(cmd.mask);
          moved_q  <= '0;
        end
        PH_EVAL: if (ev_pop) phase <= PH_XFER;
        PH_XFER: if (ev_move) begin
          remain_q <= remain_q & ~pick;
          moved_q  <= moved_q + CNT_W'(1);
          if (ev_last) phase <= PH_NULL;
        end
        PH_NULL: if (ev_pop) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: reported size follows the latched selection
  assert_size_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EVAL) |-> (rsp_word[7:0] == 8'($countones(mask_q) * 4)));
  // R5: popping the first primitive opens the transfer phase
  assert_eval_then_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_pop && phase == PH_EVAL) |=> (phase == PH_XFER));
  // R5: popping the null primitive returns to idle
  assert_null_then_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_pop && phase == PH_NULL) |=> (phase == PH_IDLE && !rsp_valid));
  // R8: no primitive offered while words are moving
  assert_quiet_xfer_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_XFER) |-> !rsp_valid);
  // R8: the null primitive comes only after every selected word moved
  assert_all_moved_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NULL) |-> (32'(moved_q) == 32'($countones(mask_q))));
  // R10: a command during an exchange leaves the latched command alone
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && phase != PH_IDLE) |=> ($stable(store_q) && $stable(mask_q)));
endmodule

// File: rtl/cp_ctlmove_seq.sv
module cp_ctlmove_seq
  import cpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              rsp_rd,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_word,
  input  logic              dat_wr,
  input  logic [WORD_W-1:0] dat_wdata,
  input  logic              dat_rd,
  output logic [WORD_W-1:0] dat_rdata,
  output logic [WORD_W-1:0] ctl_reg,
  output logic [WORD_W-1:0] sts_reg,
  output logic [WORD_W-1:0] iar_reg
);
  cmd_t                        cmd;
  phase_t                      phase;
  logic                        store_q;
  logic [NREG-1:0]             pick, wen;
  logic [NREG-1:0][WORD_W-1:0] regs_q;
  logic [WORD_W-1:0]           rdata;

  cpm_decode u_dec (.cmd_word(cmd_word), .cmd(cmd));

  cpm_seq u_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd(cmd), .rsp_rd(rsp_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .phase(phase), .store_q(store_q),
    .pick(pick), .wen(wen), .rsp_valid(rsp_valid), .rsp_word(rsp_word)
  );

  cpm_regfile #(.W(WORD_W)) u_rf (
    .clk(clk), .rst(rst), .wen(wen), .wdata(dat_wdata), .rd_sel(pick),
    .regs_q(regs_q), .rdata(rdata)
  );

  assign dat_rdata = (phase == PH_XFER && store_q) ? rdata : '0;
  assign ctl_reg   = regs_q[2];
  assign sts_reg   = regs_q[1];
  assign iar_reg   = regs_q[0];

  // R7: registers change only on a load-direction write in the transfer phase
  assert_regs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(dat_wr && phase == PH_XFER && !store_q) |=> $stable(regs_q));
  // R6: store data is zero outside a store transfer
  assert_rdata_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !(phase == PH_XFER && store_q) |-> (dat_rdata == '0));
endmodule

// File: tb/cp_ctlmove_seq_test.sv
`timescale 1ns/1ps
module cp_ctlmove_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0, rsp_rd = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [31:0] dat_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_word;
  logic [31:0] dat_rdata, ctl_reg, sts_reg, iar_reg;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cp_ctlmove_seq uut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .rsp_rd(rsp_rd),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_rd(dat_rd), .dat_rdata(dat_rdata), .ctl_reg(ctl_reg), .sts_reg(sts_reg),
    .iar_reg(iar_reg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: 0 idle, 1 first primitive, 2 transfer, 3 null primitive
  int          ph = 0;
  bit          mst;
  int          mcls, mbytes;
  int          order_q[$];
  logic [31:0] mreg [3];
  bit          model_ok = 1'b0;

  function automatic int exp_class(bit st, bit [2:0] m);
    int n = int'(m[0]) + int'(m[1]) + int'(m[2]);
    if (n >= 2) return st ? 5 : 2;
    if (m == 3'b001) return st ? 3 : 0;
    return st ? 4 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; order_q.delete(); model_ok = 1'b1;
      foreach (mreg[i]) mreg[i] = '0;
    end else begin
      case (ph)
        0: if (cmd_wr && cmd_word[15:14] == 2'b10 && cmd_word[9:0] == 10'd0) begin
          bit [2:0] m;
          m = (cmd_word[12:10] == 3'b000) ? 3'b001 : cmd_word[12:10];
          mst = cmd_word[13];
          order_q.delete();
          for (int r = 2; r >= 0; r--) if (m[r]) order_q.push_back(r);
          mbytes = 4 * order_q.size();
          mcls = exp_class(mst, m);
          ph = 1;
        end
        1: if (rsp_rd) ph = 2;
        2: if (mst ? dat_rd : dat_wr) begin
          if (!mst) mreg[order_q[0]] = dat_wdata;
          void'(order_q.pop_front());
          if (order_q.size() == 0) ph = 3;
        end
        default: if (rsp_rd) ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_ok && !done) begin
      logic [15:0] er;
      logic [31:0] ed;
      er = (ph == 1) ? {3'b001, 1'b1, 1'b0, 3'(mcls), 8'(mbytes)} : 16'h0000;
      ed = (ph == 2 && mst) ? mreg[order_q[0]] : 32'h0;
      chk("R5 rsp_valid", {31'd0, rsp_valid}, {31'd0, (ph == 1 || ph == 3)});
      chk("R5 rsp_word", {16'd0, rsp_word}, {16'd0, er});
      chk("R6 dat_rdata", dat_rdata, ed);
      chk("R7 ctl_reg", ctl_reg, mreg[2]);
      chk("R7 sts_reg", sts_reg, mreg[1]);
      chk("R7 iar_reg", iar_reg, mreg[0]);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic do_cmd(input bit dir, input bit [2:0] sel);
    cmd_word = {2'b10, dir, sel, 10'd0}; cmd_wr = 1'b1; tick(); cmd_wr = 1'b0;
  endtask
  task automatic pop(); rsp_rd = 1'b1; tick(); rsp_rd = 1'b0; endtask
  task automatic wr(input logic [31:0] d); dat_wr = 1'b1; dat_wdata = d; tick(); dat_wr = 1'b0; endtask
  task automatic rd(); dat_rd = 1'b1; tick(); dat_rd = 1'b0; endtask

  task automatic summary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    chk("R9 reset ctl", ctl_reg, 32'h0);
    chk("R9 reset idle", {31'd0, rsp_valid}, 32'h0);

    // R1: malformed command words are ignored
    cmd_word = 16'hC000; cmd_wr = 1'b1; tick();
    cmd_word = 16'h9C01; tick(); cmd_wr = 1'b0;
    chk("R1 bad word ignored", {31'd0, rsp_valid}, 32'h0);

    // Load all three: R2 12 bytes, R4 memory class
    do_cmd(1'b0, 3'b111);
    chk("R2 R4 load all", {16'd0, rsp_word}, 32'h320C);
    pop();
    wr(32'hAAAA_0001);
    chk("R8 no null mid-transfer", {31'd0, rsp_valid}, 32'h0);
    dat_rd = 1'b1; tick(); dat_rd = 1'b0;
    chk("R7 wrong strobe ignored", sts_reg, 32'h0);
    do_cmd(1'b1, 3'b001);
    chk("R10 busy command ignored", {31'd0, rsp_valid}, 32'h0);
    wr(32'hBBBB_0002);
    wr(32'hCCCC_0003);
    chk("R8 null after last", {15'd0, rsp_valid, rsp_word}, 32'h0001_0000);
    pop();
    chk("R6 order ctl", ctl_reg, 32'hAAAA_0001);
    chk("R6 order sts", sts_reg, 32'hBBBB_0002);
    chk("R6 order iar", iar_reg, 32'hCCCC_0003);

    // Store control and instruction address: R4 memory alterable, R6 skip
    do_cmd(1'b1, 3'b101);
    chk("R2 R4 store pair", {16'd0, rsp_word}, 32'h3508);
    pop();
    chk("R6 first store word", dat_rdata, 32'hAAAA_0001);
    rd();
    chk("R6 skip status", dat_rdata, 32'hCCCC_0003);
    rd(); pop();

    // R3: reserved select acts as instruction address only
    do_cmd(1'b0, 3'b000);
    chk("R3 alias rsp", {16'd0, rsp_word}, 32'h3004);
    pop(); wr(32'h1234_5678); pop();
    chk("R3 iar written", iar_reg, 32'h1234_5678);
    chk("R3 ctl untouched", ctl_reg, 32'hAAAA_0001);

    do_cmd(1'b1, 3'b100);
    chk("R4 single store data alterable", {16'd0, rsp_word}, 32'h3404);
    pop(); rd(); pop();
    do_cmd(1'b0, 3'b010);
    chk("R4 single load data", {16'd0, rsp_word}, 32'h3104);
    pop(); wr(32'h0F0F_0F0F); pop();
    chk("R7 status load", sts_reg, 32'h0F0F_0F0F);
    do_cmd(1'b1, 3'b001);
    chk("R4 single store alterable", {16'd0, rsp_word}, 32'h3304);
    pop(); rd(); pop();

    // Random traffic checked by the model every cycle
    for (int c = 0; c < 6000; c++) begin
      cmd_wr    = ($urandom_range(0, 3) == 0);
      cmd_word  = ($urandom_range(0, 4) == 0) ? 16'($urandom) :
                  {2'b10, 1'($urandom), 3'($urandom), 10'd0};
      rsp_rd    = ($urandom_range(0, 2) == 0);
      dat_wr    = ($urandom_range(0, 1) == 0);
      dat_rd    = ($urandom_range(0, 1) == 0);
      dat_wdata = $urandom;
      tick();
    end
    cmd_wr = 1'b0; rsp_rd = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0;

    // R9: reset during a transfer
    do_cmd(1'b0, 3'b000);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R9 reset clears ctl", ctl_reg, 32'h0);
    chk("R9 reset clears iar", iar_reg, 32'h0);
    chk("R9 reset idle", {31'd0, rsp_valid}, 32'h0);
    tick();
    summary();
  end
endmodule